// File: doc/BRIEF.md
# Transmit Self-Test Frame Generator

This block produces test traffic on a byte-wide gigabit transmit bus that carries one byte per clock. Software writes a configuration word. The word holds an enable bit, a frame-size select, a gap select and a frame count. Setting the enable bit starts transmission. Each frame is a preamble, a start delimiter, a pseudo-random payload and a CRC-32 trailer. The frames are separated by a fixed idle gap. The bus has an 8-bit data lane `txd` and a transmit-enable strobe `tx_en`.

A non-zero count gives a counted burst. After the last frame the generator clears the enable bit by itself. A count of zero gives an unending stream. Software stops that stream by writing the enable bit to 0, and the frame already on the wire still completes. Frame size and gap are latched at the start of each frame.

The controller is a state machine with six named states:
- `S_IDLE`: waits for the enable bit.
- `S_PRE`: sends seven preamble bytes.
- `S_SFD`: sends the delimiter and seeds the payload and CRC generators.
- `S_PAY`: sends the payload bytes.
- `S_FCS`: sends four CRC bytes.
- `S_GAP`: holds the bus idle for the gap.

The transitions are:
- IDLE→PRE when enabled.
- PRE→SFD after byte 7.
- SFD→PAY.
- PAY→FCS after the last payload byte.
- FCS→GAP when more frames follow.
- FCS→IDLE on the last counted frame or when the enable bit is clear.
- GAP→PRE at the end of the gap while enabled.
- GAP→IDLE at the end of the gap once the enable bit has been cleared.

Top module: `bist_tx_gen`

## Requirements
- R1: After reset the enable readback `en_bit`, `tx_en` and `txd` are all 0, and they stay 0 until a configuration write sets the enable bit.
- R2: Every frame starts with seven bytes of 0x55 followed by one byte of 0xD5.
- R3: The payload is 60 bytes when the size select is 0 and 1514 bytes when it is 1. The preamble, delimiter and CRC are not counted in these lengths.
- R4: The payload comes from a PRBS-7 generator with feedback x^7+x^6+1, reseeded to all ones at every frame. Each new bit is the XOR of the two top state bits and is shifted in at the bottom. Payload bit i of a byte is the i-th new bit.
- R5: The payload is followed by four CRC-32 bytes, least significant byte first. This is the reflected 0xEDB88320 CRC with initial value all ones and a complemented result. A receiver that runs the same CRC over the payload and the trailer ends with 0xDEBB20E3.
- R6: Between frames of one run, `tx_en` is low for exactly 12 clocks when the gap select is 0 and exactly 1200 clocks when it is 1.
- R7: With a count N greater than 0, exactly N frames are sent. `en_bit` then clears by itself and the bus stays idle.
- R8: With a count of 0, frames continue without end. Writing the enable bit to 0 lets the frame in progress finish in full, and no further frame starts.
- R9: `txd` is 0x00 in every clock in which `tx_en` is low.
- R10: A write that sets the enable bit in the same clock as the self-clear takes priority. `en_bit` stays 1 and a fresh burst of the written count follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-clock configuration write strobe |
| wr_enable | input | 1 | Enable bit value to write |
| wr_long | input | 1 | Frame-size select to write (1 = 1514 payload bytes) |
| wr_gap | input | 1 | Gap select to write (1 = 1200 clocks) |
| wr_count | input | CNT_W | Frame count to write (0 = continuous) |
| en_bit | output | 1 | Current enable bit |
| txd | output | 8 | Transmit data byte |
| tx_en | output | 1 | Transmit enable |

## Verification
The self-clear at the final CRC byte of a counted burst can land in the same clock as a software write to the enable bit. The bench watches the byte stream and finds the clock that carries the final CRC byte of the second frame. It then places a write that sets the enable bit on exactly the edge that ends that byte. The outcome is judged at the ports: `en_bit` must read 1 on the next half-cycle, and a second burst of two intact frames must follow, for four frames in total.

// File: rtl/bist_tx_pkg.sv
package bist_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_SFD,
        S_PAY,
        S_FCS,
        S_GAP
    } bist_state_e;

    localparam logic [7:0] PRE_BYTE   = 8'h55;
    localparam logic [7:0] SFD_BYTE   = 8'hD5;
    localparam int         PRE_COUNT  = 7;
    localparam int         FCS_COUNT  = 4;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

endpackage

// File: rtl/bist_prbs7.sv
module bist_prbs7 #(
    parameter logic [6:0] SEED = 7'h7F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       advance,
    output logic [7:0] byte_out
);

    logic [6:0] lfsr_q;
    logic [6:0] lfsr_nx;

    always_comb begin
        logic [6:0] s;
        logic       nb;
        s = lfsr_q;
        byte_out = 8'h00;
        for (int i = 0; i < 8; i++) begin
            nb = s[6] ^ s[5];
            byte_out[i] = nb;
            s = {s[5:0], nb};
        end
        lfsr_nx = s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (load) begin
            lfsr_q <= SEED;
        end else if (advance) begin
            lfsr_q <= lfsr_nx;
        end
    end

    // R4: a maximal-length generator never reaches the all-zero lock-up state
    p_prbs_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 7'h00);

endmodule

// File: rtl/bist_crc32.sv
module bist_crc32
    import bist_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        update,
    input  logic [7:0]  data,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;
    logic [31:0] crc_nx;

    always_comb begin
        logic [31:0] c;
        c = crc_q;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) begin
                c = (c >> 1) ^ CRC_POLY;
            end else begin
                c = c >> 1;
            end
        end
        crc_nx = c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init) begin
            crc_q <= '1;
        end else if (update) begin
            crc_q <= crc_nx;
        end
    end

    assign fcs = ~crc_q;

    // R5: seeding and accumulation never coincide
    p_crc_ctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(init && update));

endmodule

// File: rtl/bist_tx_fsm.sv
module bist_tx_fsm
    import bist_tx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SHORT_LEN = 60,
    parameter int LONG_LEN  = 1514,
    parameter int SHORT_GAP = 12,
    parameter int LONG_GAP  = 1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             long_sel,
    input  logic             gap_sel,
    input  logic [CNT_W-1:0] frame_count,
    input  logic [7:0]       prbs_byte,
    input  logic [31:0]      fcs,
    output logic             prbs_load,
    output logic             prbs_adv,
    output logic             crc_init,
    output logic             crc_upd,
    output logic             burst_done,
    output logic [7:0]       txd,
    output logic             tx_en
);

    localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
    localparam int MAX_GAP = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
    localparam int MAX_V   = (MAX_LEN > MAX_GAP) ? MAX_LEN : MAX_GAP;
    localparam int TIMER_W = $clog2(MAX_V + 1);

    bist_state_e            state, state_nx;
    logic [TIMER_W-1:0]     cnt, cnt_nx;
    logic [CNT_W-1:0]       done_q, done_nx;
    logic                   long_q, long_nx;
    logic                   gap_q, gap_nx;

    logic [TIMER_W-1:0]     len_sel;
    logic [TIMER_W-1:0]     gap_len;
    logic [CNT_W:0]         done_inc;
    logic                   last_frame;
    logic                   fcs_end;

    assign len_sel    = long_q ? TIMER_W'(LONG_LEN) : TIMER_W'(SHORT_LEN);
    assign gap_len    = gap_q  ? TIMER_W'(LONG_GAP) : TIMER_W'(SHORT_GAP);
    assign done_inc   = {1'b0, done_q} + (CNT_W+1)'(1);
    assign last_frame = (frame_count != '0) && (done_inc >= {1'b0, frame_count});
    assign fcs_end    = (state == S_FCS) && (cnt == TIMER_W'(FCS_COUNT - 1));
    assign burst_done = fcs_end && last_frame;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        done_nx  = done_q;
        long_nx  = long_q;
        gap_nx   = gap_q;
        unique case (state)
            S_IDLE: begin
                if (en) begin
                    state_nx = S_PRE;
                    cnt_nx   = '0;
                    done_nx  = '0;
                    long_nx  = long_sel;
                    gap_nx   = gap_sel;
                end
            end
            S_PRE: begin
                if (cnt == TIMER_W'(PRE_COUNT - 1)) begin
                    state_nx = S_SFD;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + TIMER_W'(1);
                end
            end
            S_SFD: begin
                state_nx = S_PAY;
                cnt_nx   = '0;
            end
            S_PAY: begin
                if (cnt + TIMER_W'(1) == len_sel) begin
                    state_nx = S_FCS;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + TIMER_W'(1);
                end
            end
            S_FCS: begin
                if (fcs_end) begin
                    done_nx  = done_inc[CNT_W-1:0];
                    cnt_nx   = '0;
                    state_nx = (last_frame || !en) ? S_IDLE : S_GAP;
                end else begin
                    cnt_nx = cnt + TIMER_W'(1);
                end
            end
            S_GAP: begin
                if (cnt + TIMER_W'(1) == gap_len) begin
                    cnt_nx = '0;
                    if (en) begin
                        state_nx = S_PRE;
                        long_nx  = long_sel;
                        gap_nx   = gap_sel;
                    end else begin
                        state_nx = S_IDLE;
                    end
                end else begin
                    cnt_nx = cnt + TIMER_W'(1);
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            done_q <= '0;
            long_q <= 1'b0;
            gap_q  <= 1'b0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            done_q <= done_nx;
            long_q <= long_nx;
            gap_q  <= gap_nx;
        end
    end

    // outputs
    always_comb begin
        txd       = 8'h00;
        tx_en     = 1'b0;
        prbs_load = 1'b0;
        prbs_adv  = 1'b0;
        crc_init  = 1'b0;
        crc_upd   = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_PRE: begin
                tx_en = 1'b1;
                txd   = PRE_BYTE;
            end
            S_SFD: begin
                tx_en     = 1'b1;
                txd       = SFD_BYTE;
                prbs_load = 1'b1;
                crc_init  = 1'b1;
            end
            S_PAY: begin
                tx_en    = 1'b1;
                txd      = prbs_byte;
                prbs_adv = 1'b1;
                crc_upd  = 1'b1;
            end
            S_FCS: begin
                tx_en = 1'b1;
                unique case (cnt[1:0])
                    2'd0: txd = fcs[7:0];
                    2'd1: txd = fcs[15:8];
                    2'd2: txd = fcs[23:16];
                    2'd3: txd = fcs[31:24];
                    default: txd = 8'h00;
                endcase
            end
            S_GAP: ;
            default: ;
        endcase
    end

    // R2: the delimiter follows the seventh preamble byte
    p_sfd_after_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SFD) |-> ($past(state) == S_PRE && $past(cnt) == TIMER_W'(PRE_COUNT - 1)));

    // R6: a gap opens only after the fourth CRC byte
    p_gap_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && $past(state) != S_GAP) |->
            ($past(state) == S_FCS && $past(cnt) == TIMER_W'(FCS_COUNT - 1)));

    // R9: idle bus carries zero data
    p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 8'h00));

    // R3: the payload counter never passes the selected length
    p_pay_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAY) |-> (cnt < len_sel));

endmodule

// File: rtl/bist_tx_gen.sv
module bist_tx_gen
    import bist_tx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SHORT_LEN = 60,
    parameter int LONG_LEN  = 1514,
    parameter int SHORT_GAP = 12,
    parameter int LONG_GAP  = 1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             wr_enable,
    input  logic             wr_long,
    input  logic             wr_gap,
    input  logic [CNT_W-1:0] wr_count,
    output logic             en_bit,
    output logic [7:0]       txd,
    output logic             tx_en
);

    logic             en_q;
    logic             long_q;
    logic             gap_q;
    logic [CNT_W-1:0] count_q;

    logic             prbs_load, prbs_adv;
    logic             crc_init, crc_upd;
    logic             burst_done;
    logic [7:0]       prbs_byte;
    logic [31:0]      fcs;

    // configuration register: a software write outranks the self-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            long_q  <= 1'b0;
            gap_q   <= 1'b0;
            count_q <= '0;
        end else if (cfg_wr) begin
            en_q    <= wr_enable;
            long_q  <= wr_long;
            gap_q   <= wr_gap;
            count_q <= wr_count;
        end else if (burst_done) begin
            en_q    <= 1'b0;
        end
    end

    assign en_bit = en_q;

    bist_tx_fsm #(
        .CNT_W     (CNT_W),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .SHORT_GAP (SHORT_GAP),
        .LONG_GAP  (LONG_GAP)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_q),
        .long_sel    (long_q),
        .gap_sel     (gap_q),
        .frame_count (count_q),
        .prbs_byte   (prbs_byte),
        .fcs         (fcs),
        .prbs_load   (prbs_load),
        .prbs_adv    (prbs_adv),
        .crc_init    (crc_init),
        .crc_upd     (crc_upd),
        .burst_done  (burst_done),
        .txd         (txd),
        .tx_en       (tx_en)
    );

    bist_prbs7 #(.SEED(7'h7F)) u_prbs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (prbs_load),
        .advance  (prbs_adv),
        .byte_out (prbs_byte)
    );

    bist_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .update (crc_upd),
        .data   (prbs_byte),
        .fcs    (fcs)
    );

    // R7: the end of a counted burst clears the enable bit unless software writes
    p_selfclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !cfg_wr) |=> !en_q);

    // R10: a write that sets enable always lands, even against the self-clear
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wr_enable) |=> en_q);

    // R1: no transmission without the enable bit having been set
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && $past(!en_q)) |-> $past(en_q, 2) || $past(cfg_wr, 2));

endmodule

// File: tb/tb_bist_tx_gen.sv
module tb_bist_tx_gen;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             wr_enable = 1'b0;
    logic             wr_long = 1'b0;
    logic             wr_gap = 1'b0;
    logic [CNT_W-1:0] wr_count = '0;
    logic             en_bit;
    logic [7:0]       txd;
    logic             tx_en;

    bist_tx_gen #(.CNT_W(CNT_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .wr_enable (wr_enable),
        .wr_long   (wr_long),
        .wr_gap    (wr_gap),
        .wr_count  (wr_count),
        .en_bit    (en_bit),
        .txd       (txd),
        .tx_en     (tx_en)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // monitor state
    logic [7:0] fbuf [0:1599];
    int  blen = 0;
    bit  in_frame = 0;
    bit  have_prev = 0;
    int  low_run = 0;
    int  n_frames = 0;
    int  exp_len = 60;
    int  exp_gap = 12;
    bit  gap_chk = 1;
    int  pre_bad = 0, len_bad = 0, pay_bad = 0, crc_bad = 0, gap_bad = 0, quiet_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ref_next(inout logic [6:0] s, output logic [7:0] b);
        logic nb;
        for (int i = 0; i < 8; i++) begin
            nb = s[6] ^ s[5];
            b[i] = nb;
            s = {s[5:0], nb};
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic judge_frame();
        logic [6:0]  s;
        logic [7:0]  b;
        logic [31:0] c;
        for (int i = 0; i < 7; i++) if (fbuf[i] != 8'h55) pre_bad++;
        if (fbuf[7] != 8'hD5) pre_bad++;
        if (blen != 8 + exp_len + 4) begin
            len_bad++;
            $display("  frame length %0d, expected %0d", blen, 8 + exp_len + 4);
        end else begin
            s = 7'h7F;
            c = '1;
            for (int i = 0; i < exp_len; i++) begin
                ref_next(s, b);
                if (fbuf[8+i] != b) pay_bad++;
            end
            for (int i = 8; i < blen; i++) c = ref_crc(c, fbuf[i]);
            if (c != 32'hDEBB20E3) crc_bad++;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                if (!in_frame) begin
                    in_frame = 1;
                    blen = 0;
                    if (have_prev && gap_chk && low_run != exp_gap) begin
                        gap_bad++;
                        $display("  gap %0d, expected %0d", low_run, exp_gap);
                    end
                end
                if (blen < 1600) fbuf[blen] = txd;
                blen++;
            end else begin
                if (txd != 8'h00) quiet_bad++;
                if (in_frame) begin
                    in_frame = 0;
                    judge_frame();
                    n_frames++;
                    have_prev = 1;
                    low_run = 1;
                end else begin
                    low_run++;
                end
            end
        end
    end

    task automatic clear_mon();
        @(posedge clk);
        have_prev = 0; n_frames = 0; low_run = 0;
        pre_bad = 0; len_bad = 0; pay_bad = 0; crc_bad = 0; gap_bad = 0; quiet_bad = 0;
    endtask

    task automatic do_write(input bit en, input bit lg, input bit gp, input int cnt);
        @(negedge clk);
        cfg_wr = 1; wr_enable = en; wr_long = lg; wr_gap = gp; wr_count = CNT_W'(cnt);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic wait_idle();
        while (en_bit || in_frame || tx_en) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic frame_checks(input string ctx);
        chk(pre_bad == 0,   {"R2 preamble/delimiter ", ctx}, pre_bad, 0);
        chk(len_bad == 0,   {"R3 payload length ", ctx}, len_bad, 0);
        chk(pay_bad == 0,   {"R4 payload bytes ", ctx}, pay_bad, 0);
        chk(crc_bad == 0,   {"R5 CRC residue ", ctx}, crc_bad, 0);
        chk(quiet_bad == 0, {"R9 quiet bus ", ctx}, quiet_bad, 0);
    endtask

    task automatic run_burst(input bit lg, input bit gp, input int cnt);
        clear_mon();
        exp_len = lg ? 1514 : 60;
        exp_gap = gp ? 1200 : 12;
        gap_chk = 1;
        do_write(1, lg, gp, cnt);
        wait_idle();
        chk(n_frames == cnt, "R7 frame count", n_frames, cnt);
        chk(en_bit == 0, "R7 enable self-clear", en_bit, 0);
        chk(gap_bad == 0, "R6 gap length", gap_bad, 0);
        frame_checks("burst");
    endtask

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected=<190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int n0;
        void'($urandom(32'd7319));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state and no activity without a write
        chk(en_bit == 0, "R1 en_bit after reset", en_bit, 0);
        chk(tx_en == 0,  "R1 tx_en after reset", tx_en, 0);
        chk(txd == 0,    "R1 txd after reset", txd, 0);
        repeat (50) @(negedge clk);
        chk(n_frames == 0 && tx_en == 0, "R1 idle without enable", n_frames, 0);

        // directed bursts
        run_burst(0, 0, 3);
        run_burst(1, 1, 2);
        run_burst(1, 0, 1);
        run_burst(0, 1, 2);

        // random bursts
        for (int k = 0; k < 4; k++) begin
            run_burst(1'($urandom % 2), 1'($urandom % 2), 1 + int'($urandom % 3));
        end

        // R8: continuous stream, stopped by software
        clear_mon();
        exp_len = 60; exp_gap = 12; gap_chk = 1;
        do_write(1, 0, 0, 0);
        repeat (400 + int'($urandom % 100)) @(negedge clk);
        chk(n_frames >= 4, "R8 stream continues past any count", n_frames, 4);
        n0 = n_frames + (in_frame ? 1 : 0);
        do_write(0, 0, 0, 0);
        wait_idle();
        chk(n_frames == n0 || n_frames == n0 + 1, "R8 stop after current frame", n_frames, n0);
        n0 = n_frames;
        repeat (2000) @(negedge clk);
        chk(n_frames == n0 && tx_en == 0, "R8 no frame after stop", n_frames, n0);
        chk(gap_bad == 0, "R6 gap in stream", gap_bad, 0);
        frame_checks("stream");

        // R10: enable write on the self-clear edge
        clear_mon();
        exp_len = 60; gap_chk = 0;
        do_write(1, 0, 0, 2);
        do @(posedge clk); while (!(n_frames == 1 && in_frame && blen == 71));
        #1;
        cfg_wr = 1; wr_enable = 1; wr_long = 0; wr_gap = 0; wr_count = CNT_W'(2);
        @(posedge clk);
        #1;
        cfg_wr = 0;
        @(negedge clk);
        chk(en_bit == 1, "R10 enable kept on collision", en_bit, 1);
        wait_idle();
        chk(n_frames == 4, "R10 second burst sent", n_frames, 4);
        chk(en_bit == 0, "R10 second burst self-clears", en_bit, 0);
        frame_checks("collision");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule